// File: doc/BRIEF.md
# Scratchpad Memory Access Router

This block sits on the data side of a processor and decides where each data access goes. There are three places an access can be served: a local instruction scratchpad SRAM, a local data scratchpad SRAM, or an external bus port. The choice depends on which programmable address region the address falls in and on three enable bits from the processor control register. Both scratchpad arrays are inferred memories inside the block. The chip-select, write-enable and word address of each array are also driven out as ports so that they can be observed.

The instruction scratchpad has a fill mode for loading it with code. A copy loop reads the code image from external memory and writes it to the scratchpad addresses. In fill mode the same address range is split by direction: reads go to the bus and writes go to the instruction SRAM. Each copied word therefore comes from outside and lands locally. An atomic swap to that range in fill mode has no defined meaning. The block does not perform such a swap. It answers it with an error response.

A scratchpad access returns its response one cycle after it is accepted. A bus access holds the core stalled until the bus answers with its ready signal.

Top module: `tcm_router`

## Requirements
- R1: When `ctl_dram_en` (control bit 16) is 1 and the address falls in the data region, the data SRAM serves the access. In the cycle of acceptance, `dram_cs` is 1, `dram_we` equals `req_write`, and `dram_addr` equals `req_addr[11:2]` (the address is taken modulo the default 1024-word array). A later read of the same word returns what was written.
- R2: When `ctl_dram_en` is 0, an access to the data region raises no `dram_cs` and goes to the bus port.
- R3: When `ctl_iram_en` (control bit 18) is 1 and `ctl_iram_load` (bit 19) is 0, the instruction SRAM serves both reads and writes in the instruction region. `iram_addr` equals `req_addr[11:2]`.
- R4: In fill mode (bits 18 and 19 both 1), a read in the instruction region goes to the bus port and raises no `iram_cs`. A write in the instruction region updates the instruction SRAM.
- R5: When `ctl_iram_en` is 0, instruction-region accesses go to the bus port, whatever the value of `ctl_iram_load`.
- R6: In fill mode, an access with `req_swap` = 1 in the instruction region touches neither SRAM nor the bus. One cycle later, `rsp_valid` and `rsp_err` are both 1. Outside that case `rsp_err` stays 0.
- R7: An address is in a region when every address bit at position 12+sel and above equals the same bit of the region base. A sel value of 0 to 4 gives a region size of 4 KB to 64 KB, and larger values act as 4. Where the two regions overlap and both are enabled, the instruction region wins.
- R8: A scratchpad access gives `rsp_valid` = 1 for exactly one cycle, on the cycle after acceptance. For a read, `rsp_rdata` carries the stored word.
- R9: A bus access raises `bus_req` and `core_stall` from the cycle after acceptance until the cycle in which `bus_ready` = 1. Address, direction, write data and strobes are held steady during that time. A request presented while `core_stall` = 1 is ignored. On the cycle after `bus_ready`, `rsp_valid` = 1 and `rsp_rdata` carries the captured `bus_rdata`.
- R10: On a scratchpad write, byte lane b (bits 8b+7:8b) changes only when `req_be[b]` = 1.
- R11: After reset, `rsp_valid`, `rsp_err`, `bus_req` and `core_stall` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Data request present |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte strobes, bit b enables lane b |
| req_swap | input | 1 | Request is part of an atomic swap |
| ctl_dram_en | input | 1 | Data SRAM enable (control bit 16) |
| ctl_iram_en | input | 1 | Instruction SRAM enable (control bit 18) |
| ctl_iram_load | input | 1 | Instruction SRAM fill mode (control bit 19) |
| iram_base | input | 32 | Instruction region base |
| iram_size_sel | input | 3 | Instruction region size, 4 KB << sel |
| dram_base | input | 32 | Data region base |
| dram_size_sel | input | 3 | Data region size, 4 KB << sel |
| iram_cs | output | 1 | Instruction SRAM select |
| iram_we | output | 1 | Instruction SRAM write enable |
| iram_addr | output | 10 | Instruction SRAM word address |
| dram_cs | output | 1 | Data SRAM select |
| dram_we | output | 1 | Data SRAM write enable |
| dram_addr | output | 10 | Data SRAM word address |
| bus_req | output | 1 | Bus transfer pending |
| bus_addr | output | 32 | Bus byte address |
| bus_write | output | 1 | Bus direction |
| bus_wdata | output | 32 | Bus write data |
| bus_be | output | 4 | Bus byte strobes |
| bus_ready | input | 1 | Bus completes the pending transfer |
| bus_rdata | input | 32 | Bus read data, valid with bus_ready |
| core_stall | output | 1 | Core must hold off new requests |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Undefined swap reported |

## Verification
The assertions assume three things about the inputs. `bus_ready` is only meaningful while `bus_req` is high. The control bits and region settings are stable across a request and its response. The region bases are aligned to their region size. The stimulus keeps to these assumptions. It changes the control bits and size selects only between transfers, uses bases aligned to 64 KB, and raises `bus_ready` only after it has seen `bus_req`. While the core is stalled, the stimulus deliberately offers extra requests so that the rule that stalled requests are ignored is exercised.

// File: rtl/tcm_pkg.sv
// Shared types for the scratchpad access router.
// Assumes: nothing beyond the standard language.
package tcm_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_IRAM = 2'd1,
        TGT_DRAM = 2'd2,
        TGT_BUS  = 2'd3
    } tcm_target_e;
endpackage

// File: rtl/tcm_region_match.sv
// Region comparator: flags an address whose bits above the region size
// equal the programmed base. Size is (1 << MIN_SHIFT) << sel, with sel
// clamped to MAX_SEL. Assumes the base is aligned to its size; low base
// bits are ignored.
module tcm_region_match #(
    parameter int ADDR_W    = 32,
    parameter int SEL_W     = 3,
    parameter int MIN_SHIFT = 12,
    parameter int MAX_SEL   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [SEL_W-1:0]  sel,
    output logic              hit
);
    logic [SEL_W-1:0]  sel_c;
    logic [ADDR_W-1:0] keep_mask;

    // Clamp the size select and build the mask of compared address bits.
    always_comb begin
        sel_c     = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
        keep_mask = {ADDR_W{1'b1}} << (MIN_SHIFT + int'(sel_c));
        hit       = ((addr ^ base) & keep_mask) == '0;
    end
endmodule

// File: rtl/tcm_steer.sv
// Target decoder: picks the instruction SRAM, data SRAM, bus, or none
// (undefined swap) for one request from the region hits and control bits.
// Assumes hits come from tcm_region_match; instruction region has priority.
module tcm_steer
    import tcm_pkg::*;
(
    input  logic        hit_i,
    input  logic        hit_d,
    input  logic        iram_en,
    input  logic        iram_load,
    input  logic        dram_en,
    input  logic        is_write,
    input  logic        is_swap,
    output tcm_target_e target,
    output logic        swap_bad
);
    logic load_active;

    // Decide the destination; fill mode splits the instruction range by direction.
    always_comb begin
        load_active = iram_en && iram_load;
        swap_bad    = hit_i && load_active && is_swap;
        if (hit_i && iram_en) begin
            if (swap_bad)
                target = TGT_NONE;
            else if (load_active && !is_write)
                target = TGT_BUS;
            else
                target = TGT_IRAM;
        end else if (hit_d && dram_en) begin
            target = TGT_DRAM;
        end else begin
            target = TGT_BUS;
        end
    end
endmodule

// File: rtl/tcm_sram.sv
// Single-port inferred SRAM with byte-lane write strobes and a registered
// read port: data for a selected address appears one cycle later.
// Assumes DATA_W is a multiple of 8; contents are not reset.
module tcm_sram #(
    parameter int WORDS  = 1024,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(WORDS),
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              cs,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    // Write only the strobed byte lanes of the selected word.
    always_ff @(posedge clk) begin
        if (cs && we) begin
            for (int b = 0; b < LANES; b++) begin
                if (be[b])
                    mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

    // Capture the selected word for the next-cycle read response.
    always_ff @(posedge clk) begin
        if (cs)
            rdata <= mem[addr];
    end
endmodule

// File: rtl/tcm_router.sv
// Data-side access router for two scratchpad SRAMs and an external bus.
// Accepts one request per cycle when not stalled; scratchpad responses
// arrive one cycle later, bus responses one cycle after bus_ready.
// Assumes control bits and region settings are steady across a transfer
// and that bus_ready is only raised while bus_req is high.
module tcm_router
    import tcm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int IRAM_WORDS = 1024,
    parameter int DRAM_WORDS = 1024,
    parameter int SEL_W      = 3,
    parameter int MIN_SHIFT  = 12,
    parameter int MAX_SEL    = 4,
    localparam int IAW       = $clog2(IRAM_WORDS),
    localparam int DAW       = $clog2(DRAM_WORDS),
    localparam int LANES     = DATA_W / 8,
    localparam int LSB       = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              req_swap,
    input  logic              ctl_dram_en,
    input  logic              ctl_iram_en,
    input  logic              ctl_iram_load,
    input  logic [ADDR_W-1:0] iram_base,
    input  logic [SEL_W-1:0]  iram_size_sel,
    input  logic [ADDR_W-1:0] dram_base,
    input  logic [SEL_W-1:0]  dram_size_sel,
    output logic              iram_cs,
    output logic              iram_we,
    output logic [IAW-1:0]    iram_addr,
    output logic              dram_cs,
    output logic              dram_we,
    output logic [DAW-1:0]    dram_addr,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [LANES-1:0]  bus_be,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              core_stall,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    logic              hit_i;
    logic              hit_d;
    logic              swap_bad;
    tcm_target_e       target;
    logic              accept;
    logic              busy_q;
    tcm_target_e       src_q;
    logic [DATA_W-1:0] bus_rd_q;
    logic [DATA_W-1:0] iram_rd;
    logic [DATA_W-1:0] dram_rd;

    // One comparator per region, same structure.
    tcm_region_match #(.ADDR_W(ADDR_W), .SEL_W(SEL_W),
                       .MIN_SHIFT(MIN_SHIFT), .MAX_SEL(MAX_SEL)) u_match_i (
        .addr(req_addr), .base(iram_base), .sel(iram_size_sel), .hit(hit_i)
    );
    tcm_region_match #(.ADDR_W(ADDR_W), .SEL_W(SEL_W),
                       .MIN_SHIFT(MIN_SHIFT), .MAX_SEL(MAX_SEL)) u_match_d (
        .addr(req_addr), .base(dram_base), .sel(dram_size_sel), .hit(hit_d)
    );

    tcm_steer u_steer (
        .hit_i(hit_i), .hit_d(hit_d),
        .iram_en(ctl_iram_en), .iram_load(ctl_iram_load), .dram_en(ctl_dram_en),
        .is_write(req_write), .is_swap(req_swap),
        .target(target), .swap_bad(swap_bad)
    );

    // Drive the SRAM strobes for an accepted request in the same cycle.
    always_comb begin
        accept    = req_valid && !busy_q;
        iram_cs   = accept && (target == TGT_IRAM);
        iram_we   = iram_cs && req_write;
        iram_addr = req_addr[LSB +: IAW];
        dram_cs   = accept && (target == TGT_DRAM);
        dram_we   = dram_cs && req_write;
        dram_addr = req_addr[LSB +: DAW];
    end

    tcm_sram #(.WORDS(IRAM_WORDS), .DATA_W(DATA_W)) u_iram (
        .clk(clk), .cs(iram_cs), .we(iram_we), .addr(iram_addr),
        .be(req_be), .wdata(req_wdata), .rdata(iram_rd)
    );
    tcm_sram #(.WORDS(DRAM_WORDS), .DATA_W(DATA_W)) u_dram (
        .clk(clk), .cs(dram_cs), .we(dram_we), .addr(dram_addr),
        .be(req_be), .wdata(req_wdata), .rdata(dram_rd)
    );

    // Track the bus transfer, the response source and the response pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            src_q     <= TGT_NONE;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            bus_rd_q  <= '0;
            bus_addr  <= '0;
            bus_write <= 1'b0;
            bus_wdata <= '0;
            bus_be    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            if (accept) begin
                src_q <= target;
                unique case (target)
                    TGT_IRAM, TGT_DRAM: rsp_valid <= 1'b1;
                    TGT_NONE: begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b1;
                    end
                    TGT_BUS: begin
                        busy_q    <= 1'b1;
                        bus_addr  <= req_addr;
                        bus_write <= req_write;
                        bus_wdata <= req_wdata;
                        bus_be    <= req_be;
                    end
                endcase
            end
            if (busy_q && bus_ready) begin
                busy_q    <= 1'b0;
                rsp_valid <= 1'b1;
                src_q     <= TGT_BUS;
                bus_rd_q  <= bus_rdata;
            end
        end
    end

    // Return data from whichever target produced the response.
    always_comb begin
        bus_req    = busy_q;
        core_stall = busy_q;
        unique case (src_q)
            TGT_IRAM: rsp_rdata = iram_rd;
            TGT_DRAM: rsp_rdata = dram_rd;
            TGT_BUS:  rsp_rdata = bus_rd_q;
            default:  rsp_rdata = '0;
        endcase
    end

    AST_DRAM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_dram_en |-> !dram_cs); // R2
    AST_IRAM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_iram_en |-> !iram_cs); // R5
    AST_LOAD_READ_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_iram_en && ctl_iram_load && !req_write) |-> !iram_cs); // R4
    AST_SWAP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit_i && ctl_iram_en && ctl_iram_load && req_swap)
        |-> (!iram_cs && !dram_cs)); // R6
    AST_SWAP_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit_i && ctl_iram_en && ctl_iram_load && req_swap)
        |=> (rsp_valid && rsp_err)); // R6
    AST_SRAM_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (iram_cs || dram_cs) |=> (rsp_valid && !rsp_err && !bus_req)); // R8
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata))); // R9
    AST_STALL_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> (!iram_cs && !dram_cs)); // R9
endmodule

// File: tb/tcm_router_test.sv
// Bench for tcm_router: a directed fill, corner cases, then seeded random traffic.
module tcm_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_swap = 1'b0;
    logic        ce_d = 1'b0, ce_i = 1'b0, ce_l = 1'b0;
    logic [31:0] ib = 32'h0080_0000, db = 32'h0090_0000;
    logic [2:0]  isel = 3'd0, dsel = 3'd0;
    logic        iram_cs, iram_we, dram_cs, dram_we;
    logic [9:0]  iram_addr, dram_addr;
    logic        bus_req, bus_write, core_stall, rsp_valid, rsp_err;
    logic [31:0] bus_addr, bus_wdata, rsp_rdata;
    logic [3:0]  bus_be;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [31:0] imem [1024];
    logic [31:0] dmem [1024];

    always #4 clk = ~clk;

    tcm_router uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_be(req_be),
        .req_swap(req_swap), .ctl_dram_en(ce_d), .ctl_iram_en(ce_i),
        .ctl_iram_load(ce_l), .iram_base(ib), .iram_size_sel(isel),
        .dram_base(db), .dram_size_sel(dsel), .iram_cs(iram_cs),
        .iram_we(iram_we), .iram_addr(iram_addr), .dram_cs(dram_cs),
        .dram_we(dram_we), .dram_addr(dram_addr), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .core_stall(core_stall), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit inr(logic [31:0] a, logic [31:0] base, logic [2:0] sel);
        int s = (sel > 3'd4) ? 4 : int'(sel);
        return ((a ^ base) >> (12 + s)) == 32'd0;
    endfunction

    // 0 = error, 1 = instruction SRAM, 2 = data SRAM, 3 = bus
    function automatic int route(logic [31:0] a, logic wr, logic sw);
        if (inr(a, ib, isel) && ce_i) begin
            if (ce_l && sw) return 0;
            if (ce_l && !wr) return 3;
            return 1;
        end
        if (inr(a, db, dsel) && ce_d) return 2;
        return 3;
    endfunction

    function automatic logic [31:0] busval(logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5a5a_3c3c;
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    task automatic do_req(input logic [31:0] a, input logic wr, input logic [31:0] wd,
                          input logic [3:0] be, input logic sw);
        int exp;
        int waits;
        logic [9:0] idx;
        exp = route(a, wr, sw);
        idx = a[11:2];
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
        req_be = be; req_swap = sw;
        #1;
        chk(iram_cs == (exp == 1), "R3/R4/R5 iram_cs", {31'd0, iram_cs}, {31'd0, exp == 1});
        chk(dram_cs == (exp == 2), "R1/R2 dram_cs", {31'd0, dram_cs}, {31'd0, exp == 2});
        if (exp == 1)
            chk(iram_we == wr && iram_addr == idx, "R3 iram we/addr", {21'd0, iram_we, iram_addr}, {21'd0, wr, idx});
        if (exp == 2)
            chk(dram_we == wr && dram_addr == idx, "R1 dram we/addr", {21'd0, dram_we, dram_addr}, {21'd0, wr, idx});
        @(negedge clk);
        req_valid = 1'b0;
        if (exp != 3) begin
            chk(rsp_valid && !bus_req, "R8 response one cycle later", {31'd0, rsp_valid}, 32'd1);
            chk(rsp_err == (exp == 0), "R6 rsp_err", {31'd0, rsp_err}, {31'd0, exp == 0});
            if (exp == 1) begin
                if (!wr) chk(rsp_rdata == imem[idx], "R8 R10 iram read data", rsp_rdata, imem[idx]);
                else imem[idx] = merge(imem[idx], wd, be);
            end
            if (exp == 2) begin
                if (!wr) chk(rsp_rdata == dmem[idx], "R8 R10 dram read data", rsp_rdata, dmem[idx]);
                else dmem[idx] = merge(dmem[idx], wd, be);
            end
            @(negedge clk);
            chk(!rsp_valid, "R8 single-cycle response", {31'd0, rsp_valid}, 32'd0);
        end else begin
            chk(bus_req && core_stall && !rsp_valid, "R9 bus pending", {30'd0, bus_req, core_stall}, 32'd3);
            chk(bus_addr == a && bus_write == wr, "R9 bus addr/dir", bus_addr, a);
            if (wr) chk(bus_wdata == wd && bus_be == be, "R9 bus wdata", bus_wdata, wd);
            waits = $urandom_range(0, 3);
            for (int k = 0; k < waits; k++) begin
                req_valid = 1'b1; req_addr = db + 32'h10; req_write = 1'b1;
                req_wdata = 32'hdead_beef; req_be = 4'hf; req_swap = 1'b0;
                #1;
                chk(!iram_cs && !dram_cs, "R9 stalled request ignored", {30'd0, iram_cs, dram_cs}, 32'd0);
                @(negedge clk);
                chk(bus_req && bus_addr == a, "R9 bus held", bus_addr, a);
            end
            req_valid = 1'b0;
            bus_ready = 1'b1; bus_rdata = busval(a);
            @(negedge clk);
            bus_ready = 1'b0;
            chk(rsp_valid && !bus_req && !core_stall && !rsp_err, "R9 bus done", {30'd0, rsp_valid, bus_req}, 32'd2);
            if (!wr) chk(rsp_rdata == busval(a), "R9 bus read data", rsp_rdata, busval(a));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!rsp_valid && !rsp_err && !bus_req && !core_stall, "R11 reset state",
            {28'd0, rsp_valid, rsp_err, bus_req, core_stall}, 32'd0);
        rst_n = 1'b1;
        // Fill both arrays: instruction SRAM through fill mode writes.
        ce_i = 1'b1; ce_l = 1'b1; ce_d = 1'b1;
        for (int i = 0; i < 1024; i++) begin
            do_req(ib + 32'(i * 4), 1'b1, 32'h1000_0000 + 32'(i * 7), 4'hf, 1'b0);
            do_req(db + 32'(i * 4), 1'b1, 32'h2000_0000 + 32'(i * 13), 4'hf, 1'b0);
        end
        // R4: fill-mode read of instruction range goes out on the bus.
        do_req(ib + 32'h40, 1'b0, '0, 4'hf, 1'b0);
        // R6: swap in fill mode.
        do_req(ib + 32'h44, 1'b1, 32'h1234_5678, 4'hf, 1'b1);
        ce_l = 1'b0;
        do_req(ib + 32'h44, 1'b0, '0, 4'hf, 1'b0);   // R6: word untouched
        // R10: byte lane write then read back.
        do_req(db + 32'h8, 1'b1, 32'haabb_ccdd, 4'b0101, 1'b0);
        do_req(db + 32'h8, 1'b0, '0, 4'hf, 1'b0);
        // R5: load bit alone has no effect.
        ce_i = 1'b0; ce_l = 1'b1;
        do_req(ib + 32'h20, 1'b1, 32'h5555_aaaa, 4'hf, 1'b0);
        do_req(ib + 32'h20, 1'b0, '0, 4'hf, 1'b0);
        // R2: data SRAM disabled.
        ce_d = 1'b0;
        do_req(db + 32'h8, 1'b0, '0, 4'hf, 1'b0);
        // R7: size boundaries and overlap priority.
        ce_i = 1'b1; ce_l = 1'b0; ce_d = 1'b1; isel = 3'd1;
        do_req(ib + 32'h1ffc, 1'b0, '0, 4'hf, 1'b0);
        do_req(ib + 32'h2000, 1'b0, '0, 4'hf, 1'b0);
        isel = 3'd7;
        do_req(ib + 32'hfffc, 1'b0, '0, 4'hf, 1'b0);
        do_req(ib + 32'h1_0000, 1'b0, '0, 4'hf, 1'b0);
        db = ib; dsel = 3'd4;
        do_req(ib + 32'h30, 1'b0, '0, 4'hf, 1'b0);
        db = 32'h0090_0000; isel = 3'd0; dsel = 3'd0;
        // Seeded random traffic across modes and regions.
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a;
            logic wr;
            logic sw;
            int reg_pick;
            if (n % 40 == 0) begin
                ce_d = 1'($urandom_range(0, 1)); ce_i = 1'($urandom_range(0, 1));
                ce_l = 1'($urandom_range(0, 1));
                isel = 3'($urandom_range(0, 4)); dsel = 3'($urandom_range(0, 4));
            end
            reg_pick = $urandom_range(0, 2);
            wr = 1'($urandom_range(0, 1));
            sw = ($urandom_range(0, 7) == 0);
            case (reg_pick)
                0: a = ib + (32'($urandom) % (32'd4096 << isel) & ~32'd3);
                1: a = db + (32'($urandom) % (32'd4096 << dsel) & ~32'd3);
                default: a = 32'h4000_0000 + (32'($urandom) & 32'h000f_fffc);
            endcase
            do_req(a, wr, 32'($urandom), wr ? 4'($urandom) : 4'hf, sw);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule